// File: doc/BRIEF.md
# Single-Wire Slave Command Sequencer

This block is the protocol layer of a slave on a single-wire, self-clocked serial bus. A physical-layer front end recovers bit timing and hands over one strobe per decoded bit, plus three event flags: the low pulse that opens a start header, a standby pulse (line held high for a long time) and a missed edge. The sequencer frames received bits into bytes, most significant bit first. After every byte it takes the master's acknowledge bit, where 1 means continue and 0 means end, and then tells the front end whether to answer with a slave acknowledge (SAK, a mid-bit edge) or to leave the slot without one (NoSAK).

The sequencer checks the device address byte and decodes the command byte. It collects a two-byte word address for the random-access commands and hands each step to a memory controller as single-cycle strobes. While the master reads, it shifts the controller's byte out on the line. It keeps the link in one of three states. Standby waits for a header. Active is inside a command. Idle ignores everything until a standby pulse. A fixed list of protocol errors sends the link to idle.

Top module: `swc_seq`

## Requirements
- R1: After reset `link_state` is 0 (standby; 1 means active, 2 means idle), and `ack_req`, `tx_en` and every controller strobe are low.
- R2: A `phy_hdr` pulse in standby starts a header byte, whose content is not checked. After it the slave always answers NoSAK. A master 1 moves on to the address byte, and a master 0 sends the link to idle.
- R3: An address byte equal to `DEV_ADDR` (0xA0) gets SAK. A master 1 then moves on to the command byte, and a master 0 returns the link to standby. Any other address byte gets NoSAK and sends the link to idle.
- R4: The valid command bytes are 0x03 (read at address), 0x06 (read at current address), 0x6C (write), 0x96 (set write enable), 0x91 (clear write enable), 0x05 (read status), 0x6E (write status), 0x6D (fill with 0x00) and 0x67 (fill with 0xFF). Any other byte gets NoSAK and sends the link to idle.
- R5: While `mem_busy` is high, 0x03, 0x06, 0x6C, 0x6E, 0x6D and 0x67 are treated as invalid under R4. 0x96, 0x91 and 0x05 are still accepted.
- R6: For 0x96, 0x91, 0x6D and 0x67, a master 0 gives SAK, a `mc_commit` pulse with `mc_op` equal to the command byte, and standby. A master 1 gives NoSAK and idle.
- R7: 0x03 and 0x6C take two word-address bytes, high byte first. After the master's 1 on the low byte, `mc_addr_vld` pulses with the 16-bit address. 0x06 and 0x05 go straight to read data.
- R8: During a read byte, `tx_en` is high for the 8 bit slots and `tx_bit` carries `mem_rdata` MSB first. The master's bit then gets SAK. Except for 0x05, it also gets a `mc_rd_adv` pulse. A 1 continues reading, and a 0 returns the link to standby.
- R9: Each data byte of 0x6C gets SAK and a `mc_wbyte_vld` pulse carrying the byte, with `mc_wstat` low. A master 0 also pulses `mc_commit` and returns the link to standby.
- R10: The data byte of 0x6E, ended by a master 0, gets SAK, `mc_wbyte_vld` with `mc_wstat` high, `mc_commit`, and standby. Ended by a master 1, it gets NoSAK and idle.
- R11: A master 0 after the command byte of 0x03, 0x06, 0x6C, 0x05 or 0x6E, or after either word-address byte, gets NoSAK and sends the link to idle.
- R12: In idle, bit strobes and `phy_hdr` have no effect, and no acknowledge is requested. `phy_standby` returns the link to standby from any state. `phy_miss` in the active state sends the link to idle.
- R13: `ack_req` is a one-cycle pulse, two clock cycles after the strobe of the master's acknowledge bit. Every controller strobe comes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_hdr | input | 1 | Header low pulse detected (one cycle) |
| phy_standby | input | 1 | Standby pulse detected (one cycle) |
| phy_miss | input | 1 | Expected edge missing (one cycle) |
| phy_bit_vld | input | 1 | One strobe per bit slot |
| phy_bit | input | 1 | Received bit value, valid with the strobe |
| mem_busy | input | 1 | Write cycle in progress |
| mem_rdata | input | 8 | Byte to send during a read byte |
| ack_req | output | 1 | Request to drive the slave acknowledge slot |
| ack_sak | output | 1 | 1 = SAK, 0 = NoSAK, valid with `ack_req` |
| tx_en | output | 1 | Slave drives the current bit slot |
| tx_bit | output | 1 | Bit to drive while `tx_en` is high |
| mc_op | output | 8 | Command byte of the current command, 0 when none |
| mc_addr_vld | output | 1 | Word address strobe |
| mc_addr | output | 16 | Word address |
| mc_wbyte_vld | output | 1 | Received data byte strobe |
| mc_wbyte | output | 8 | Received data byte |
| mc_wstat | output | 1 | Data byte is for the status register |
| mc_rd_adv | output | 1 | Advance the read pointer |
| mc_commit | output | 1 | Command ended properly; start its action |
| link_state | output | 2 | 0 standby, 1 active, 2 idle |

## Verification
The bench builds the block with its default device address, 0xA0, so the address check can be passed and also refused with a neighbouring value. The bench plays the memory controller itself, with a pointer-derived data pattern and a separate status value. This lets it follow the read pointer across a random read, a current-address read and a sequential read. It drives `mem_busy` to exercise the busy gating of each command class.

// File: rtl/swc_pkg.sv
`timescale 1ns/1ps
package swc_pkg;

  localparam int BYTE_W  = 8;
  localparam int WADDR_W = 16;

  // command bytes
  localparam logic [7:0] OPC_RD_AT   = 8'h03;
  localparam logic [7:0] OPC_RD_CUR  = 8'h06;
  localparam logic [7:0] OPC_WR_AT   = 8'h6C;
  localparam logic [7:0] OPC_WEN_SET = 8'h96;
  localparam logic [7:0] OPC_WEN_CLR = 8'h91;
  localparam logic [7:0] OPC_ST_RD   = 8'h05;
  localparam logic [7:0] OPC_ST_WR   = 8'h6E;
  localparam logic [7:0] OPC_FILL0   = 8'h6D;
  localparam logic [7:0] OPC_FILL1   = 8'h67;

  localparam logic [1:0] LINK_STBY = 2'd0;
  localparam logic [1:0] LINK_ACT  = 2'd1;
  localparam logic [1:0] LINK_IDLE = 2'd2;

  typedef enum logic [3:0] {
    PH_STBY, PH_HDR, PH_ADDR, PH_CMD, PH_AHI, PH_ALO,
    PH_RDAT, PH_WDAT, PH_WSR, PH_IDLE
  } phase_e;

  // how a command continues after its opcode byte
  typedef enum logic [2:0] {
    CK_BAD,      // unknown opcode
    CK_SINGLE,   // ends right after the opcode
    CK_ADDR,     // two word-address bytes follow
    CK_STREAM,   // read data follows at once
    CK_STAT_WR   // one status byte follows
  } cmd_kind_e;

  function automatic cmd_kind_e opc_kind(input logic [7:0] b);
    case (b)
      OPC_WEN_SET, OPC_WEN_CLR, OPC_FILL0, OPC_FILL1: return CK_SINGLE;
      OPC_RD_AT, OPC_WR_AT:                           return CK_ADDR;
      OPC_RD_CUR, OPC_ST_RD:                          return CK_STREAM;
      OPC_ST_WR:                                      return CK_STAT_WR;
      default:                                        return CK_BAD;
    endcase
  endfunction

  // commands refused while the array is being written
  function automatic logic opc_busy_blocked(input logic [7:0] b);
    return (b == OPC_RD_AT) || (b == OPC_RD_CUR) || (b == OPC_WR_AT) ||
           (b == OPC_ST_WR) || (b == OPC_FILL0)  || (b == OPC_FILL1);
  endfunction

  function automatic logic [1:0] link_of(input phase_e p);
    case (p)
      PH_STBY: return LINK_STBY;
      PH_IDLE: return LINK_IDLE;
      default: return LINK_ACT;
    endcase
  endfunction

endpackage

// File: rtl/swc_framer.sv
`timescale 1ns/1ps
module swc_framer #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          tx_mode,
  input  logic          bit_vld,
  input  logic          bit_in,
  input  logic [BW-1:0] rd_byte,
  output logic          ack_stb,
  output logic          ack_bit,
  output logic [BW-1:0] rx_byte,
  output logic          tx_en,
  output logic          tx_bit
);
  localparam int CNT_W = $clog2(BW + 1);
  localparam logic [CNT_W-1:0] ACK_SLOT = CNT_W'(BW);

  logic [CNT_W-1:0] cnt_q;
  logic [BW-1:0]    sr_q;
  logic [BW-1:0]    tx_sh;
  logic             slot_is_ack;

  assign slot_is_ack = (cnt_q == ACK_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      sr_q    <= '0;
      ack_stb <= 1'b0;
      ack_bit <= 1'b0;
    end else if (clr) begin
      cnt_q   <= '0;
      ack_stb <= 1'b0;
    end else begin
      ack_stb <= 1'b0;
      if (en && bit_vld) begin
        if (slot_is_ack) begin
          ack_stb <= 1'b1;
          ack_bit <= bit_in;
          cnt_q   <= '0;
        end else begin
          if (!tx_mode) sr_q <= {sr_q[BW-2:0], bit_in};
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rx_byte = sr_q;
  assign tx_sh   = rd_byte << cnt_q;
  assign tx_bit  = tx_sh[BW-1];
  assign tx_en   = en && tx_mode && !slot_is_ack;

  // R13: acknowledge strobe only follows a bit strobe
  assert_ack_after_bit_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> $past(bit_vld));
  // R8: slot counter never passes the acknowledge slot
  assert_slot_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ACK_SLOT);

endmodule

// File: rtl/swc_decode.sv
`timescale 1ns/1ps
module swc_decode
  import swc_pkg::*;
(
  input  logic [7:0] opc,
  input  logic       busy,
  output cmd_kind_e  kind,
  output logic       ok
);
  logic refused;

  assign kind    = opc_kind(opc);
  assign refused = busy && opc_busy_blocked(opc);
  assign ok      = (kind != CK_BAD) && !refused;
endmodule

// File: rtl/swc_ctl.sv
`timescale 1ns/1ps
module swc_ctl
  import swc_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hA0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phy_hdr,
  input  logic               phy_standby,
  input  logic               phy_miss,
  input  logic               ack_stb,
  input  logic               ack_bit,
  input  logic [7:0]         rx_byte,
  input  cmd_kind_e          dec_kind,
  input  logic               dec_ok,
  output phase_e             phase,
  output logic               fr_clr,
  output logic               fr_en,
  output logic               fr_tx,
  output logic               ack_req,
  output logic               ack_sak,
  output logic [7:0]         mc_op,
  output logic               mc_addr_vld,
  output logic [WADDR_W-1:0] mc_addr,
  output logic               mc_wbyte_vld,
  output logic [7:0]         mc_wbyte,
  output logic               mc_wstat,
  output logic               mc_rd_adv,
  output logic               mc_commit
);
  phase_e     ph_q, ph_d;
  logic [7:0] ahi_q;
  logic d_ack, d_sak, d_addr, d_wb, d_wst, d_adv, d_commit;
  logic d_op_ld, d_op_clr, d_ahi;
  logic ev_to_idle;   // named event: this cycle decides to go idle

  always_comb begin
    ph_d = ph_q;
    d_ack = 1'b0; d_sak = 1'b0; d_addr = 1'b0; d_wb = 1'b0; d_wst = 1'b0;
    d_adv = 1'b0; d_commit = 1'b0; d_op_ld = 1'b0; d_op_clr = 1'b0; d_ahi = 1'b0;
    if (phy_standby) begin
      ph_d = PH_STBY;
      d_op_clr = 1'b1;
    end else if (ph_q == PH_STBY) begin
      if (phy_hdr) begin
        ph_d = PH_HDR;
        d_op_clr = 1'b1;
      end
    end else if (ph_q == PH_IDLE) begin
      ph_d = PH_IDLE;
    end else if (phy_miss) begin
      ph_d = PH_IDLE;
    end else if (ack_stb) begin
      d_ack = 1'b1;
      case (ph_q)
        PH_HDR: ph_d = ack_bit ? PH_ADDR : PH_IDLE;
        PH_ADDR: begin
          if (rx_byte != DEV_ADDR) ph_d = PH_IDLE;
          else begin
            d_sak = 1'b1;
            ph_d  = ack_bit ? PH_CMD : PH_STBY;
          end
        end
        PH_CMD: begin
          d_op_ld = dec_ok;
          if (!dec_ok) ph_d = PH_IDLE;
          else if (dec_kind == CK_SINGLE) begin
            if (ack_bit) ph_d = PH_IDLE;
            else begin
              d_sak = 1'b1; d_commit = 1'b1; ph_d = PH_STBY;
            end
          end else if (!ack_bit) ph_d = PH_IDLE;
          else begin
            d_sak = 1'b1;
            case (dec_kind)
              CK_ADDR:   ph_d = PH_AHI;
              CK_STREAM: ph_d = PH_RDAT;
              default:   ph_d = PH_WSR;
            endcase
          end
        end
        PH_AHI: begin
          if (ack_bit) begin
            d_sak = 1'b1; d_ahi = 1'b1; ph_d = PH_ALO;
          end else ph_d = PH_IDLE;
        end
        PH_ALO: begin
          if (ack_bit) begin
            d_sak = 1'b1; d_addr = 1'b1;
            ph_d = (mc_op == OPC_WR_AT) ? PH_WDAT : PH_RDAT;
          end else ph_d = PH_IDLE;
        end
        PH_RDAT: begin
          d_sak = 1'b1;
          d_adv = (mc_op != OPC_ST_RD);
          ph_d  = ack_bit ? PH_RDAT : PH_STBY;
        end
        PH_WDAT: begin
          d_sak = 1'b1; d_wb = 1'b1;
          if (!ack_bit) begin
            d_commit = 1'b1; ph_d = PH_STBY;
          end
        end
        PH_WSR: begin
          if (ack_bit) ph_d = PH_IDLE;
          else begin
            d_sak = 1'b1; d_wb = 1'b1; d_wst = 1'b1; d_commit = 1'b1;
            ph_d = PH_STBY;
          end
        end
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  assign ev_to_idle = (ph_d == PH_IDLE) && (ph_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_STBY;
      ahi_q <= '0;
      ack_req <= 1'b0; ack_sak <= 1'b0;
      mc_op <= '0; mc_addr_vld <= 1'b0; mc_addr <= '0;
      mc_wbyte_vld <= 1'b0; mc_wbyte <= '0; mc_wstat <= 1'b0;
      mc_rd_adv <= 1'b0; mc_commit <= 1'b0;
    end else begin
      ph_q         <= ph_d;
      ack_req      <= d_ack;
      ack_sak      <= d_sak;
      mc_addr_vld  <= d_addr;
      mc_wbyte_vld <= d_wb;
      mc_wstat     <= d_wst;
      mc_rd_adv    <= d_adv;
      mc_commit    <= d_commit;
      if (d_ahi)  ahi_q <= rx_byte;
      if (d_addr) mc_addr <= {ahi_q, rx_byte};
      if (d_wb)   mc_wbyte <= rx_byte;
      if (d_op_clr)     mc_op <= '0;
      else if (d_op_ld) mc_op <= rx_byte;
    end
  end

  assign phase  = ph_q;
  assign fr_en  = (ph_q != PH_STBY) && (ph_q != PH_IDLE);
  assign fr_tx  = (ph_q == PH_RDAT);
  assign fr_clr = phy_standby || phy_miss || (phy_hdr && ph_q == PH_STBY);

  // R13: acknowledge request lasts exactly one cycle
  assert_ack_one_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |=> !ack_req);
  // R13: acknowledge request comes one cycle after the framer's strobe
  assert_ack_timing_R13: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req |-> $past(ack_stb));
  // R12: idle is left only through a standby pulse
  assert_idle_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE && !phy_standby) |=> (ph_q == PH_IDLE));
  // R2: NoSAK only after the header or on the way to idle
  assert_nosak_where_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !ack_sak) |-> (ph_q == PH_ADDR || ph_q == PH_IDLE));
  // R11: an acknowledge that sends the link idle is a NoSAK
  assert_idle_nosak_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_to_idle && d_ack) |=> (ack_req && !ack_sak));
  // R9: a data byte strobe always comes with SAK
  assert_wbyte_sak_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mc_wbyte_vld |-> (ack_req && ack_sak));
  // R6: a commit leaves the link in standby
  assert_commit_standby_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mc_commit |-> (ph_q == PH_STBY));

endmodule

// File: rtl/swc_seq.sv
`timescale 1ns/1ps
module swc_seq
  import swc_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hA0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               phy_hdr,
  input  logic               phy_standby,
  input  logic               phy_miss,
  input  logic               phy_bit_vld,
  input  logic               phy_bit,
  input  logic               mem_busy,
  input  logic [BYTE_W-1:0]  mem_rdata,
  output logic               ack_req,
  output logic               ack_sak,
  output logic               tx_en,
  output logic               tx_bit,
  output logic [BYTE_W-1:0]  mc_op,
  output logic               mc_addr_vld,
  output logic [WADDR_W-1:0] mc_addr,
  output logic               mc_wbyte_vld,
  output logic [BYTE_W-1:0]  mc_wbyte,
  output logic               mc_wstat,
  output logic               mc_rd_adv,
  output logic               mc_commit,
  output logic [1:0]         link_state
);
  logic              fr_clr, fr_en, fr_tx;
  logic              ack_stb, ack_bit;
  logic [BYTE_W-1:0] rx_byte;
  cmd_kind_e         dec_kind;
  logic              dec_ok;
  phase_e            phase;

  swc_framer #(.BW(BYTE_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .clr(fr_clr), .en(fr_en), .tx_mode(fr_tx),
    .bit_vld(phy_bit_vld), .bit_in(phy_bit), .rd_byte(mem_rdata),
    .ack_stb(ack_stb), .ack_bit(ack_bit), .rx_byte(rx_byte),
    .tx_en(tx_en), .tx_bit(tx_bit)
  );

  swc_decode u_decode (
    .opc(rx_byte), .busy(mem_busy), .kind(dec_kind), .ok(dec_ok)
  );

  swc_ctl #(.DEV_ADDR(DEV_ADDR)) u_ctl (
    .clk(clk), .rst_n(rst_n), .phy_hdr(phy_hdr), .phy_standby(phy_standby),
    .phy_miss(phy_miss), .ack_stb(ack_stb), .ack_bit(ack_bit),
    .rx_byte(rx_byte), .dec_kind(dec_kind), .dec_ok(dec_ok),
    .phase(phase), .fr_clr(fr_clr), .fr_en(fr_en), .fr_tx(fr_tx),
    .ack_req(ack_req), .ack_sak(ack_sak), .mc_op(mc_op),
    .mc_addr_vld(mc_addr_vld), .mc_addr(mc_addr),
    .mc_wbyte_vld(mc_wbyte_vld), .mc_wbyte(mc_wbyte), .mc_wstat(mc_wstat),
    .mc_rd_adv(mc_rd_adv), .mc_commit(mc_commit)
  );

  assign link_state = link_of(phase);

  // R1: the link only reports the three defined states
  assert_link_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
    link_state != 2'd3);

endmodule

// File: tb/swc_seq_tb.sv
`timescale 1ns/1ps
module swc_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phy_hdr = 0, phy_standby = 0, phy_miss = 0, phy_bit_vld = 0, phy_bit = 0;
  logic mem_busy = 0;
  logic [7:0]  mem_rdata;
  logic        ack_req, ack_sak, tx_en, tx_bit;
  logic [7:0]  mc_op, mc_wbyte;
  logic        mc_addr_vld, mc_wbyte_vld, mc_wstat, mc_rd_adv, mc_commit;
  logic [15:0] mc_addr;
  logic [1:0]  link_state;

  always #2.5 clk = ~clk;

  swc_seq u_dut (.*);

  // bench plays the memory controller
  logic [7:0] ptr = 8'h00;
  localparam logic [7:0] STAT_VAL = 8'hC5;
  assign mem_rdata = (mc_op == 8'h05) ? STAT_VAL : (ptr ^ 8'h3C);
  always @(posedge clk) begin
    if (mc_addr_vld) ptr <= mc_addr[7:0];
    else if (mc_rd_adv) ptr <= ptr + 8'd1;
  end

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle pulse tally, compared against the model's expectations
  int s_ack = 0, s_adr = 0, s_wb = 0, s_adv = 0, s_cm = 0;
  int e_ack = 0, e_adr = 0, e_wb = 0, e_adv = 0, e_cm = 0;
  always @(negedge clk) if (rst_n) begin
    if (ack_req) s_ack++;
    if (mc_addr_vld) s_adr++;
    if (mc_wbyte_vld) s_wb++;
    if (mc_rd_adv) s_adv++;
    if (mc_commit) s_cm++;
  end

  // behavioural reference: phases as integers
  localparam int P_STBY = 0, P_HDR = 1, P_ADDR = 2, P_CMD = 3, P_AHI = 4,
                 P_ALO = 5, P_RD = 6, P_WR = 7, P_WSR = 8, P_IDLE = 9;
  int mp = P_STBY;
  logic [7:0]  mcmd = 0, mahi = 0;
  logic [15:0] maddr = 0;
  bit es, eadr, ewb, ewst, eadv, ecm, eack;
  string etag;

  function automatic int link_exp(input int p);
    if (p == P_STBY) return 0;
    if (p == P_IDLE) return 2;
    return 1;
  endfunction

  function automatic bit known(input logic [7:0] b);
    return b inside {8'h03, 8'h06, 8'h6C, 8'h96, 8'h91, 8'h05, 8'h6E, 8'h6D, 8'h67};
  endfunction

  task automatic model(input logic [7:0] b, input bit mak);
    es = 0; eadr = 0; ewb = 0; ewst = 0; eadv = 0; ecm = 0; eack = 1;
    case (mp)
      P_HDR: begin etag = "R2"; mp = mak ? P_ADDR : P_IDLE; end
      P_ADDR: begin
        etag = "R3";
        if (b != 8'hA0) mp = P_IDLE;
        else begin es = 1; mp = mak ? P_CMD : P_STBY; end
      end
      P_CMD: begin
        bit single, blocked;
        single  = b inside {8'h96, 8'h91, 8'h6D, 8'h67};
        blocked = mem_busy && (b inside {8'h03, 8'h06, 8'h6C, 8'h6E, 8'h6D, 8'h67});
        etag = blocked ? "R5" : (!known(b) ? "R4" : (single ? "R6" : "R11"));
        if (!known(b) || blocked) mp = P_IDLE;
        else begin
          mcmd = b;
          if (single) begin
            if (mak) mp = P_IDLE; else begin es = 1; ecm = 1; mp = P_STBY; end
          end else if (!mak) mp = P_IDLE;
          else begin
            es = 1; etag = "R7";
            if (b == 8'h03 || b == 8'h6C) mp = P_AHI;
            else if (b == 8'h6E) mp = P_WSR;
            else mp = P_RD;
          end
        end
      end
      P_AHI: begin
        etag = "R7";
        if (mak) begin es = 1; mahi = b; mp = P_ALO; end else mp = P_IDLE;
      end
      P_ALO: begin
        etag = "R7";
        if (mak) begin
          es = 1; eadr = 1; maddr = {mahi, b};
          mp = (mcmd == 8'h6C) ? P_WR : P_RD;
        end else mp = P_IDLE;
      end
      P_RD: begin
        etag = "R8"; es = 1;
        if (mcmd != 8'h05) begin eadv = 1; maddr = maddr + 16'd1; end
        mp = mak ? P_RD : P_STBY;
      end
      P_WR: begin
        etag = "R9"; es = 1; ewb = 1;
        if (!mak) begin ecm = 1; mp = P_STBY; end
      end
      P_WSR: begin
        etag = "R10";
        if (mak) mp = P_IDLE;
        else begin es = 1; ewb = 1; ewst = 1; ecm = 1; mp = P_STBY; end
      end
      default: begin etag = "R12"; eack = 0; end
    endcase
  endtask

  // one byte plus the master acknowledge bit; checks the slave's answer
  task automatic xfer(input logic [7:0] b, input bit mak);
    bit reading;
    logic [7:0] rexp, wr_byte;
    reading = (mp == P_RD);
    rexp = (mcmd == 8'h05) ? STAT_VAL : (maddr[7:0] ^ 8'h3C);
    for (int k = 0; k < 8; k++) begin
      if (reading) begin
        chk(tx_en === 1'b1, "R8 tx_en", tx_en, 1);
        chk(tx_bit === rexp[7-k], "R8 tx_bit", tx_bit, rexp[7-k]);
      end else begin
        chk(tx_en === 1'b0, "R8 tx_en off", tx_en, 0);
      end
      phy_bit_vld = 1; phy_bit = b[7-k];
      @(negedge clk); phy_bit_vld = 0;
      repeat (2) @(negedge clk);
    end
    phy_bit_vld = 1; phy_bit = mak;
    @(negedge clk); phy_bit_vld = 0;
    @(negedge clk);
    wr_byte = b;
    model(b, mak);
    if (eack) begin
      e_ack++; if (eadr) e_adr++; if (ewb) e_wb++; if (eadv) e_adv++; if (ecm) e_cm++;
      chk(ack_req === 1'b1, {etag, " R13 ack_req"}, ack_req, 1);
      chk(ack_sak === es, {etag, " ack_sak"}, ack_sak, es);
      chk(mc_addr_vld === eadr, {etag, " mc_addr_vld"}, mc_addr_vld, eadr);
      if (eadr) chk(mc_addr === maddr, "R7 mc_addr", mc_addr, maddr);
      chk(mc_wbyte_vld === ewb, {etag, " mc_wbyte_vld"}, mc_wbyte_vld, ewb);
      if (ewb) begin
        chk(mc_wbyte === wr_byte, {etag, " mc_wbyte"}, mc_wbyte, wr_byte);
        chk(mc_wstat === ewst, {etag, " mc_wstat"}, mc_wstat, ewst);
      end
      chk(mc_rd_adv === eadv, {etag, " mc_rd_adv"}, mc_rd_adv, eadv);
      chk(mc_commit === ecm, {etag, " mc_commit"}, mc_commit, ecm);
      if (ecm) chk(mc_op === mcmd, "R6 mc_op", mc_op, mcmd);
    end else begin
      chk(ack_req === 1'b0, "R12 no ack", ack_req, 0);
    end
    chk(link_state === 2'(link_exp(mp)), {etag, " link_state"}, link_state, link_exp(mp));
    repeat (2) @(negedge clk);
  endtask

  task automatic header();
    phy_hdr = 1; @(negedge clk); phy_hdr = 0;
    if (mp == P_STBY) mp = P_HDR;
    @(negedge clk);
    xfer(8'h55, 1);
  endtask

  task automatic open_dev();
    header(); xfer(8'hA0, 1);
  endtask

  task automatic stby();
    phy_standby = 1; @(negedge clk); phy_standby = 0; mp = P_STBY;
    @(negedge clk);
    chk(link_state === 2'd0, "R12 standby pulse", link_state, 0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(link_state === 2'd0, "R1 link", link_state, 0);
    chk(ack_req === 1'b0 && tx_en === 1'b0, "R1 outputs", {ack_req, tx_en}, 0);
    chk({mc_addr_vld, mc_wbyte_vld, mc_rd_adv, mc_commit} === 4'b0, "R1 strobes",
        {mc_addr_vld, mc_wbyte_vld, mc_rd_adv, mc_commit}, 0);
    rst_n = 1; @(negedge clk);
    chk(link_state === 2'd0, "R1 link after release", link_state, 0);

    // random read with sequential continuation
    open_dev(); xfer(8'h03, 1); xfer(8'h00, 1); xfer(8'h10, 1);
    xfer(8'h00, 1); xfer(8'h00, 1); xfer(8'h00, 0);
    // current-address read
    open_dev(); xfer(8'h06, 1); xfer(8'h00, 1); xfer(8'h00, 0);
    // write two bytes
    open_dev(); xfer(8'h6C, 1); xfer(8'h00, 1); xfer(8'h20, 1);
    xfer(8'h11, 1); xfer(8'h22, 0);
    // single-byte commands
    open_dev(); xfer(8'h96, 0);
    open_dev(); xfer(8'h91, 0);
    open_dev(); xfer(8'h67, 0);
    open_dev(); xfer(8'h96, 1);            // MAK after single-byte -> idle
    header(); xfer(8'hA0, 1);              // ignored in idle
    stby();
    // address mismatch and NoMAK after address
    header(); xfer(8'hA1, 1); stby();
    header(); xfer(8'hA0, 0);
    // unknown command
    open_dev(); xfer(8'h42, 1); stby();
    // busy gating
    mem_busy = 1;
    open_dev(); xfer(8'h03, 1); stby();
    open_dev(); xfer(8'h6D, 0); stby();
    open_dev(); xfer(8'h05, 1); xfer(8'h00, 1); xfer(8'h00, 0);
    open_dev(); xfer(8'h96, 0);
    mem_busy = 0;
    // status write
    open_dev(); xfer(8'h6E, 1); xfer(8'h0C, 0);
    open_dev(); xfer(8'h6E, 1); xfer(8'h0C, 1); stby();
    // premature ends
    open_dev(); xfer(8'h03, 0); stby();
    open_dev(); xfer(8'h6C, 1); xfer(8'h00, 0); stby();
    // header ended by NoMAK
    phy_hdr = 1; @(negedge clk); phy_hdr = 0; mp = P_HDR; @(negedge clk);
    xfer(8'h55, 0); stby();
    // missed edge mid-command
    open_dev();
    phy_miss = 1; @(negedge clk); phy_miss = 0; mp = P_IDLE; @(negedge clk);
    chk(link_state === 2'd2, "R12 missed edge", link_state, 2);
    xfer(8'h03, 1);
    stby();
    phy_miss = 1; @(negedge clk); phy_miss = 0; @(negedge clk);
    chk(link_state === 2'd0, "R12 miss in standby", link_state, 0);

    repeat (4) @(negedge clk);
    chk(s_ack == e_ack, "R13 ack pulse count", s_ack, e_ack);
    chk(s_adr == e_adr, "R7 addr strobe count", s_adr, e_adr);
    chk(s_wb == e_wb, "R9 wbyte strobe count", s_wb, e_wb);
    chk(s_adv == e_adv, "R8 adv strobe count", s_adv, e_adv);
    chk(s_cm == e_cm, "R6 commit count", s_cm, e_cm);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule